// File: doc/BRIEF.md
# Video-Line Interrupt Timers

This block produces two interrupts locked to video timing. A line timer counts scan lines. The count clears at the vertical-blank strobe and advances at every horizontal-blank strobe. The line timer pulses `line_irq` when the count reaches a programmed compare line. A dot timer is reloaded at every horizontal-blank strobe and counts down on a pixel-rate tick enable. It pulses `dot_irq` when the count runs out.

A mode setting can restrict the dot timer so that it fires only on the line the line timer has selected. This places a mid-line interrupt on one chosen scan line. Software programs three shadow settings through a small write port: the compare line, the reload value and the mode. The compare line takes effect at the next vertical-blank strobe. The reload value and the mode take effect at the next horizontal-blank strobe. A count in progress is therefore never disturbed.

Top module: `vline_irq_timers`

## Requirements
- R1: After reset both interrupt outputs are low, the line count is 0, and the dot timer is disarmed: pixel ticks produce no `dot_irq` until the first horizontal-blank strobe.
- R2: The line count (10 bits) clears to 0 on `vblank_start` and increments by one on `hblank_start`, wrapping from 1023 to 0. When both strobes coincide, the count becomes 0.
- R3: `line_irq` is high for exactly the one cycle after a clock edge at which a strobe was sampled and the resulting line count equals the active compare line.
- R4: A compare line written with `wr_sel`=0 (bits 9:0 of `wr_data`) becomes active at the next `vblank_start` and is already used for that strobe's own match. Until then, the previous compare line stays in force.
- R5: On `hblank_start` the dot timer loads the reload value written with `wr_sel`=1 (bits 8:0) and arms. With reload N≥1, `dot_irq` pulses in the cycle after the Nth sampled `px_tick`. With reload 0, it pulses in the cycle after the first sampled `px_tick`.
- R6: The dot timer fires at most once per load. After firing, it holds at zero and ignores further ticks until the next `hblank_start`.
- R7: When `hblank_start` and `px_tick` coincide, the reload wins and that tick is not counted.
- R8: Mode register (`wr_sel`=2), bit 0 enables the dot interrupt. The mode is captured at `hblank_start`. A load made while bit 0 is clear produces no `dot_irq` for that line, even if the bit is set afterwards.
- R9: With mode bit 8 set at load time, `dot_irq` occurs only on a line whose count, after that horizontal-blank strobe, equals the active compare line. With bit 8 clear, it occurs on every line.
- R10: A write with `wr_sel`=3 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vblank_start | input | 1 | One-cycle strobe at the start of vertical blank |
| hblank_start | input | 1 | One-cycle strobe at the start of horizontal blank |
| px_tick | input | 1 | Pixel-rate count enable |
| wr_en | input | 1 | Setting write strobe |
| wr_sel | input | 2 | Setting select: 0 compare line, 1 reload, 2 mode, 3 none |
| wr_data | input | DATA_W (10) | Write data |
| line_irq | output | 1 | Line-match interrupt pulse |
| dot_irq | output | 1 | Dot-timer interrupt pulse |

## Verification
On every cycle, the assertions check the following:
- the line count clears on vertical blank and steps on horizontal blank;
- each interrupt traces back to a strobe or a counted tick in the previous cycle;
- the dot timer holds at zero and fires once per load;
- a load never coincides with a fire;
- every `dot_irq` was permitted by the enable and line gate captured at load.

Only the bench scenarios can show the following:
- that the exact tick count to a fire matches the reload value;
- that a compare line written mid-frame waits for the next vertical blank;
- that mode changes after a load have no effect;
- that the 10-bit line count wraps.

// File: rtl/vlt_pkg.sv
package vlt_pkg;

  // Setting selector codes on the write port
  typedef enum logic [1:0] {
    SEL_CMP    = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_MODE   = 2'd2,
    SEL_NONE   = 2'd3
  } vlt_sel_e;

  // Mode field positions in write data
  localparam int MODE_EN_BIT   = 0;
  localparam int MODE_LINE_BIT = 8;

  typedef struct packed {
    logic only_line;
    logic enable;
  } vlt_mode_t;

  // Write data must hold the widest field and the mode bits
  function automatic int vlt_data_w(input int line_w, input int dot_w);
    int w;
    w = MODE_LINE_BIT + 1;
    if (line_w > w) w = line_w;
    if (dot_w > w) w = dot_w;
    return w;
  endfunction

endpackage

// File: rtl/vlt_regs.sv
module vlt_regs
  import vlt_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 9,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LINE_W-1:0] cmp_shadow,
  output logic [DOT_W-1:0]  reload_shadow,
  output vlt_mode_t         mode_shadow
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_shadow    <= '0;
      reload_shadow <= '0;
      mode_shadow   <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CMP:    cmp_shadow    <= wr_data[LINE_W-1:0];
        SEL_RELOAD: reload_shadow <= wr_data[DOT_W-1:0];
        SEL_MODE: begin
          mode_shadow.enable    <= wr_data[MODE_EN_BIT];
          mode_shadow.only_line <= wr_data[MODE_LINE_BIT];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vlt_line_timer.sv
module vlt_line_timer #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vblank_start,
  input  logic              hblank_start,
  input  logic [LINE_W-1:0] cmp_shadow,
  output logic [LINE_W-1:0] line_cnt,
  output logic              line_evt,
  output logic              match_nxt,
  output logic              line_irq
);

  // Line count after this cycle's strobes; vertical blank dominates
  function automatic logic [LINE_W-1:0] next_line(input logic v, input logic h,
                                                  input logic [LINE_W-1:0] cur);
    if (v) return '0;
    if (h) return cur + 1'b1;
    return cur;
  endfunction

  logic [LINE_W-1:0] cmp_active;
  logic [LINE_W-1:0] line_nxt;
  logic [LINE_W-1:0] cmp_eff;

  always_comb begin
    line_evt  = vblank_start | hblank_start;
    line_nxt  = next_line(vblank_start, hblank_start, line_cnt);
    cmp_eff   = vblank_start ? cmp_shadow : cmp_active;
    match_nxt = (line_nxt == cmp_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt   <= '0;
      cmp_active <= '0;
      line_irq   <= 1'b0;
    end else begin
      line_irq <= line_evt && match_nxt;
      if (line_evt) line_cnt <= line_nxt;
      if (vblank_start) cmp_active <= cmp_shadow;
    end
  end

endmodule

// File: rtl/vlt_dot_timer.sv
module vlt_dot_timer
  import vlt_pkg::*;
#(
  parameter int DOT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hblank_start,
  input  logic             px_tick,
  input  logic [DOT_W-1:0] reload_shadow,
  input  vlt_mode_t        mode_shadow,
  input  logic             match_nxt,
  output logic [DOT_W-1:0] dot_cnt,
  output logic             armed,
  output logic             en_act,
  output logic             sel_act,
  output logic             gate_q,
  output logic             dot_fire,
  output logic             dot_irq
);

  // Count after one tick, saturating at zero
  function automatic logic [DOT_W-1:0] step_down(input logic [DOT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  // A tick at this count ends the run (reload 0 ends on its first tick)
  function automatic logic ends_run(input logic [DOT_W-1:0] c);
    return c <= DOT_W'(1);
  endfunction

  logic load;
  logic pass;

  always_comb begin
    load     = hblank_start;
    dot_fire = !load && px_tick && armed && ends_run(dot_cnt);
    pass     = en_act && (!sel_act || gate_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_cnt <= '0;
      armed   <= 1'b0;
      en_act  <= 1'b0;
      sel_act <= 1'b0;
      gate_q  <= 1'b0;
      dot_irq <= 1'b0;
    end else begin
      dot_irq <= dot_fire && pass;
      if (load) begin
        dot_cnt <= reload_shadow;
        armed   <= 1'b1;
        en_act  <= mode_shadow.enable;
        sel_act <= mode_shadow.only_line;
        gate_q  <= match_nxt;
      end else if (px_tick && armed) begin
        dot_cnt <= step_down(dot_cnt);
        if (dot_fire) armed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vline_irq_timers.sv
module vline_irq_timers
  import vlt_pkg::*;
#(
  parameter  int LINE_W = 10,
  parameter  int DOT_W  = 9,
  localparam int DATA_W = vlt_data_w(LINE_W, DOT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vblank_start,
  input  logic              hblank_start,
  input  logic              px_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              line_irq,
  output logic              dot_irq
);

  // Internal events named for the bound checker
  logic [LINE_W-1:0] cmp_shadow;
  logic [DOT_W-1:0]  reload_shadow;
  vlt_mode_t         mode_shadow;
  logic [LINE_W-1:0] line_cnt;
  logic              line_evt;
  logic              match_nxt;
  logic [DOT_W-1:0]  dot_cnt;
  logic              armed;
  logic              en_act;
  logic              sel_act;
  logic              gate_q;
  logic              dot_fire;

  vlt_regs #(.LINE_W(LINE_W), .DOT_W(DOT_W), .DATA_W(DATA_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .cmp_shadow    (cmp_shadow),
    .reload_shadow (reload_shadow),
    .mode_shadow   (mode_shadow)
  );

  vlt_line_timer #(.LINE_W(LINE_W)) u_line (
    .clk          (clk),
    .rst_n        (rst_n),
    .vblank_start (vblank_start),
    .hblank_start (hblank_start),
    .cmp_shadow   (cmp_shadow),
    .line_cnt     (line_cnt),
    .line_evt     (line_evt),
    .match_nxt    (match_nxt),
    .line_irq     (line_irq)
  );

  vlt_dot_timer #(.DOT_W(DOT_W)) u_dot (
    .clk           (clk),
    .rst_n         (rst_n),
    .hblank_start  (hblank_start),
    .px_tick       (px_tick),
    .reload_shadow (reload_shadow),
    .mode_shadow   (mode_shadow),
    .match_nxt     (match_nxt),
    .dot_cnt       (dot_cnt),
    .armed         (armed),
    .en_act        (en_act),
    .sel_act       (sel_act),
    .gate_q        (gate_q),
    .dot_fire      (dot_fire),
    .dot_irq       (dot_irq)
  );

endmodule

// File: rtl/vlt_checker.sv
module vlt_checker #(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vblank_start,
  input logic              hblank_start,
  input logic              px_tick,
  input logic [LINE_W-1:0] line_cnt,
  input logic              line_evt,
  input logic [DOT_W-1:0]  dot_cnt,
  input logic              armed,
  input logic              en_act,
  input logic              sel_act,
  input logic              gate_q,
  input logic              dot_fire,
  input logic              line_irq,
  input logic              dot_irq
);

  assert_idle_until_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dot_irq |-> $past(armed));

  assert_vblank_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_start |=> line_cnt == '0);

  assert_hblank_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank_start && !vblank_start) |=> line_cnt == LINE_W'($past(line_cnt) + 1'b1));

  assert_line_irq_from_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq |-> $past(line_evt));

  assert_load_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_start |=> armed);

  assert_dot_irq_from_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dot_irq |-> $past(dot_fire && px_tick));

  assert_single_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dot_irq |=> !dot_irq);

  assert_hold_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_cnt == '0 && !hblank_start) |=> dot_cnt == '0);

  assert_load_beats_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_start |=> !dot_irq);

  assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dot_irq |-> $past(en_act));

  assert_line_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dot_irq |-> $past(!sel_act || gate_q));

endmodule

bind vline_irq_timers vlt_checker #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vblank_start (vblank_start),
  .hblank_start (hblank_start),
  .px_tick      (px_tick),
  .line_cnt     (line_cnt),
  .line_evt     (line_evt),
  .dot_cnt      (dot_cnt),
  .armed        (armed),
  .en_act       (en_act),
  .sel_act      (sel_act),
  .gate_q       (gate_q),
  .dot_fire     (dot_fire),
  .line_irq     (line_irq),
  .dot_irq      (dot_irq)
);

// File: tb/vline_irq_timers_bench.sv
module vline_irq_timers_bench;

  localparam int LW   = 10;
  localparam int DW   = 9;
  localparam int XW   = 10;
  localparam int CLKP = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vblank_start = 1'b0;
  logic          hblank_start = 1'b0;
  logic          px_tick = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [XW-1:0] wr_data = '0;
  logic          line_irq;
  logic          dot_irq;

  int checks = 0;
  int errors = 0;
  bit auto_chk = 1'b0;

  always #(CLKP/2) clk = ~clk;

  vline_irq_timers u_vline_irq_timers (
    .clk(clk), .rst_n(rst_n), .vblank_start(vblank_start), .hblank_start(hblank_start),
    .px_tick(px_tick), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .line_irq(line_irq), .dot_irq(dot_irq)
  );

  // Reference model built from the requirements
  logic [LW-1:0] m_line, m_cmp_sh, m_cmp_act;
  logic [DW-1:0] m_rel_sh, m_cnt;
  logic          m_en_sh, m_sel_sh, m_armed, m_en, m_sel, m_gate;
  logic          m_eline, m_edot;

  function automatic logic [LW-1:0] line_after(input logic v, input logic h,
                                               input logic [LW-1:0] cur);
    return v ? '0 : (h ? LW'(cur + 1) : cur);
  endfunction

  function automatic logic tick_ends(input logic [DW-1:0] c);
    return (c == 0) || (c == 1);
  endfunction

  always @(posedge clk) begin
    logic [LW-1:0] nl;
    logic          hit, fire;
    if (!rst_n) begin
      m_line = '0; m_cmp_sh = '0; m_cmp_act = '0; m_rel_sh = '0; m_cnt = '0;
      m_en_sh = 0; m_sel_sh = 0; m_armed = 0; m_en = 0; m_sel = 0; m_gate = 0;
      m_eline = 0; m_edot = 0;
    end else begin
      nl   = line_after(vblank_start, hblank_start, m_line);
      hit  = (nl == (vblank_start ? m_cmp_sh : m_cmp_act));
      fire = 1'b0;
      if (hblank_start) begin
        m_cnt = m_rel_sh; m_armed = 1; m_en = m_en_sh; m_sel = m_sel_sh; m_gate = hit;
      end else if (px_tick && m_armed) begin
        if (tick_ends(m_cnt)) begin fire = 1; m_armed = 0; m_cnt = '0; end
        else m_cnt = m_cnt - 1'b1;
      end
      m_eline = (vblank_start || hblank_start) && hit;
      m_edot  = fire && m_en && (!m_sel || m_gate);
      if (vblank_start) m_cmp_act = m_cmp_sh;
      m_line = nl;
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_cmp_sh = wr_data[LW-1:0];
          2'd1: m_rel_sh = wr_data[DW-1:0];
          2'd2: begin m_en_sh = wr_data[0]; m_sel_sh = wr_data[8]; end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive one cycle from a falling edge; return at the next falling edge
  task automatic step(input logic v, input logic h, input logic t,
                      input logic we = 1'b0, input logic [1:0] sel = 2'd0,
                      input logic [XW-1:0] d = '0);
    vblank_start = v; hblank_start = h; px_tick = t;
    wr_en = we; wr_sel = sel; wr_data = d;
    @(negedge clk);
    vblank_start = 0; hblank_start = 0; px_tick = 0; wr_en = 0;
    if (auto_chk) begin
      check("R3", "line_irq vs model", line_irq, m_eline);
      check("R5", "dot_irq vs model", dot_irq, m_edot);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [XW-1:0] d);
    step(0, 0, 0, 1'b1, sel, d);
  endtask

  initial begin
    #(CLKP * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and no dot timer before first load
    check("R1", "line_irq after reset", line_irq, 1'b0);
    check("R1", "dot_irq after reset", dot_irq, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 1);
      check("R1", "dot_irq tick before load", dot_irq, 1'b0);
    end

    // R3: compare line 3
    wr(2'd0, 10'd3);
    step(1, 0, 0);
    check("R3", "no match at line 0", line_irq, 1'b0);
    step(0, 1, 0); check("R3", "line 1", line_irq, 1'b0);
    step(0, 1, 0); check("R3", "line 2", line_irq, 1'b0);
    step(0, 1, 0); check("R3", "line 3 match", line_irq, 1'b1);
    step(0, 0, 0); check("R3", "pulse width", line_irq, 1'b0);
    step(0, 1, 0); check("R3", "line 4", line_irq, 1'b0);

    // R4: new compare waits for vertical blank
    wr(2'd0, 10'd5);
    step(0, 1, 0); check("R4", "line 5 before vblank", line_irq, 1'b0);
    step(1, 0, 0); check("R4", "vblank line 0", line_irq, 1'b0);
    for (int i = 1; i <= 5; i++) begin
      step(0, 1, 0);
      check("R4", "line after vblank", line_irq, (i == 5));
    end

    // R2: coincident strobes give line 0, and the count wraps
    wr(2'd0, 10'd0);
    step(1, 1, 0); check("R2", "coincident strobes line 0", line_irq, 1'b1);
    step(0, 1, 0); check("R2", "line 1", line_irq, 1'b0);
    for (int i = 1; i <= 1023; i++) begin
      step(0, 1, 0);
      if (i == 1022) check("R2", "line 1023", line_irq, 1'b0);
      if (i == 1023) check("R2", "wrap to 0", line_irq, 1'b1);
    end

    // R5/R6: reload 4 on every line
    wr(2'd2, 10'h001);
    wr(2'd1, 10'd4);
    step(0, 1, 0);
    for (int i = 1; i <= 4; i++) begin
      step(0, 0, 1);
      check("R5", "reload 4 tick", dot_irq, (i == 4));
    end
    step(0, 0, 0); check("R6", "single pulse", dot_irq, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 1);
      check("R6", "hold at zero", dot_irq, 1'b0);
    end

    // R5: reload 0 fires on first tick
    wr(2'd1, 10'd0);
    step(0, 1, 0);
    step(0, 0, 1); check("R5", "reload 0 first tick", dot_irq, 1'b1);
    step(0, 0, 1); check("R6", "reload 0 no refire", dot_irq, 1'b0);

    // R7: reload wins over a coincident tick
    wr(2'd1, 10'd2);
    step(0, 1, 0);
    step(0, 0, 1); check("R7", "first tick", dot_irq, 1'b0);
    step(0, 1, 1); check("R7", "reload with tick", dot_irq, 1'b0);
    step(0, 0, 1); check("R7", "tick 1 after reload", dot_irq, 1'b0);
    step(0, 0, 1); check("R7", "tick 2 after reload", dot_irq, 1'b1);

    // R8: enable captured at load
    wr(2'd2, 10'h000);
    wr(2'd1, 10'd1);
    step(0, 1, 0);
    wr(2'd2, 10'h001);
    step(0, 0, 1); check("R8", "disabled at load", dot_irq, 1'b0);
    step(0, 1, 0);
    step(0, 0, 1); check("R8", "enabled at load", dot_irq, 1'b1);

    // R9: only the compare line
    wr(2'd2, 10'h101);
    wr(2'd0, 10'd2);
    step(1, 0, 0);
    step(0, 1, 0);
    step(0, 0, 1); check("R9", "line 1 gated", dot_irq, 1'b0);
    step(0, 1, 0); check("R9", "line 2 line_irq", line_irq, 1'b1);
    step(0, 0, 1); check("R9", "line 2 fires", dot_irq, 1'b1);
    step(0, 1, 0);
    step(0, 0, 1); check("R9", "line 3 gated", dot_irq, 1'b0);

    // R10: selector 3 changes nothing
    wr(2'd2, 10'h001);
    wr(2'd3, 10'h000);
    step(0, 1, 0); check("R10", "compare line unchanged", line_irq, 1'b0);
    step(0, 0, 1); check("R10", "reload and enable unchanged", dot_irq, 1'b1);

    // Random traffic against the model
    auto_chk = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      logic v, h, t, we;
      logic [1:0] sel;
      logic [XW-1:0] d;
      v   = ($urandom_range(0, 149) == 0);
      h   = ($urandom_range(0, 7) == 0);
      t   = $urandom_range(0, 1);
      we  = ($urandom_range(0, 29) == 0);
      sel = 2'($urandom_range(0, 3));
      d   = XW'($urandom) & 10'h10F;
      step(v, h, t, we, sel, d);
    end
    auto_chk = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule